// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters on a single line. It is meant for multidrop buses where many listeners share one line. A supplied strobe runs at sixteen times the bit rate, and the block samples the synchronised line on every strobe. A falling edge begins a start bit. That start bit is accepted only if the line is still low at the middle sample. The block then takes each data bit at mid-bit, least significant bit first. A mode input selects 8 or 9 data bits. When the stop bit is sampled, the assembled character is placed on the data output and a receive-full flag is raised.

A second flag reports an idle line. It is raised once, after one full character time of continuous ones that follows a received character. Each flag has its own interrupt enable, and the two enabled flags are ORed into a single interrupt request.

Software can put the receiver into standby. While the block is in standby, the interrupt request is held low. The hardware leaves standby and clears the standby bit on one of two events, chosen by a wake-select input: an idle line, or an address-marked character. Software reaches the block through a control write strobe, a status-read strobe and a data-read strobe. Receiver-enable writes are accepted only while the module-enable input is high.

Top module: `uart_wake_rx`

## Requirements
- R1: A start bit is accepted only if the line is low at the 8th of 16 samples. The data bits are taken at mid-bit, least significant bit first. There are 8 data bits when `nine_bit`=0 and 9 when `nine_bit`=1. In 8-bit mode `rx_data[8]` reads 0. `rx_full` rises when the stop bit is sampled, and `rx_data` then holds the new character.
- R2: `irq` is `(rx_full & ctrl_q[2]) | (rx_idle & ctrl_q[3])` while not in standby. Bit 2 of the control word is the full-interrupt enable and bit 3 is the idle-interrupt enable. Reset clears both enables.
- R3: While `ctrl_q[0]` (receiver enable) is 0, no character is received. `rx_full`, `rx_idle` and `rx_data` keep their values.
- R4: While `ctrl_q[1]` (standby) is 1, `irq` is 0.
- R5: Software sets standby by writing 1 to control bit 1, and only software can set it. With `wake_sel`=0, an idle-line event clears standby. With `wake_sel`=1, a received character whose top data bit is 1 clears it: bit 8 in 9-bit mode, bit 7 in 8-bit mode. That waking character is loaded and flagged like any other.
- R6: A control write while `mod_en`=0 leaves `ctrl_q[0]` unchanged. The write still updates bits 1 to 3.
- R7: After reset, `ctrl_q`=0, `rx_full`=0, `rx_idle`=0 and `irq`=0.
- R8: `rx_idle` rises after 10 bit times of continuous ones in 8-bit mode, or 11 in 9-bit mode, measured from the end of a received character. A shorter gap does not raise it. It rises at most once per received character.
- R9: A flag that was 1 when `stat_rd` pulsed is cleared by a later `data_rd` pulse. A `data_rd` pulse without that earlier status read leaves the flags unchanged.
- R10: A low pulse that ends before the 8th sample does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample strobe at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| mod_en | input | 1 | Module enable; gates writes to the receiver-enable bit |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | Standby exit: 0 on idle line, 1 on address mark |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control word: [0] receiver enable, [1] standby, [2] full-interrupt enable, [3] idle-interrupt enable |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| ctrl_q | output | 4 | Current control word |
| rx_full | output | 1 | Receive-full flag |
| rx_idle | output | 1 | Idle-line flag |
| rx_data | output | 9 | Last received character |
| irq | output | 1 | Receiver interrupt request |

## Verification
The assertions check the following on every cycle:
- the interrupt request stays low while the block is in standby;
- the receiver-enable bit does not move on a write made while the module is disabled;
- standby is set only by a control write;
- an address-marked character in standby clears the standby bit;
- a flag falls only on a data read;
- the receive-full flag never rises while reception is off.

Other behaviours show only in the bench scenarios. These are:
- the sampling points and the bit order;
- the choice between 8-bit and 9-bit characters;
- rejection of a short start glitch;
- the exact idle-gap threshold, against a gap that is too short;
- wakeup by idle line;
- the order of status read and data read needed to clear a flag.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
   typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;
   localparam int unsigned CTRL_W  = 4;
   localparam int unsigned CB_RXEN = 0;
   localparam int unsigned CB_STBY = 1;
   localparam int unsigned CB_FIE  = 2;
   localparam int unsigned CB_IIE  = 3;
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], d};
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uwr_framer.sv
module uwr_framer
   import uwr_pkg::*;
#(
   parameter int unsigned OVS   = 16,
   parameter int unsigned LONG  = 9,
   parameter int unsigned SHORT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            rx,
   input  logic            rx_en,
   input  logic            nine_bit,
   output logic            busy,
   output logic            done,
   output logic [LONG-1:0] data
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned HALF = OVS / 2;
   localparam int unsigned IW   = $clog2(LONG + 1);

   fr_state_e       st;
   logic [CW-1:0]   cnt;
   logic [IW-1:0]   idx;
   logic [LONG-1:0] sh;
   logic [IW-1:0]   last;
   logic            at_end;

   assign last   = nine_bit ? IW'(LONG - 1) : IW'(SHORT - 1);
   assign at_end = (cnt == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= FR_IDLE;
         cnt <= '0;
         idx <= '0;
         sh  <= '0;
      end else if (!rx_en) begin
         st  <= FR_IDLE;
         cnt <= '0;
         idx <= '0;
      end else if (tick) begin
         unique case (st)
            FR_IDLE: begin
               if (!rx) begin
                  st  <= FR_START;
                  cnt <= CW'(1);
               end
            end
            FR_START: begin
               if (cnt == CW'(HALF - 1)) begin
                  cnt <= '0;
                  if (!rx) begin
                     st  <= FR_DATA;
                     idx <= '0;
                     sh  <= '0;
                  end else begin
                     st <= FR_IDLE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_DATA: begin
               if (at_end) begin
                  cnt     <= '0;
                  sh[idx] <= rx;
                  if (idx == last) st <= FR_STOP;
                  else             idx <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_STOP: begin
               if (at_end) begin
                  cnt <= '0;
                  st  <= FR_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (st != FR_IDLE);
   assign done = rx_en && tick && (st == FR_STOP) && at_end;
   assign data = sh;

   // R1: a character completes only from the stop state
   AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (st == FR_IDLE)); // R1
endmodule

// File: rtl/uwr_idle_det.sv
module uwr_idle_det #(
   parameter int unsigned OVS   = 16,
   parameter int unsigned LONG  = 9,
   parameter int unsigned SHORT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx,
   input  logic rx_en,
   input  logic busy,
   input  logic done,
   input  logic nine_bit,
   output logic idle_evt
);
   localparam int unsigned LIM_L = (LONG + 2) * OVS;
   localparam int unsigned LIM_S = (SHORT + 2) * OVS;
   localparam int unsigned CW    = $clog2(LIM_L + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          armed;

   assign lim = nine_bit ? CW'(LIM_L - 1) : CW'(LIM_S - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         armed    <= 1'b0;
         idle_evt <= 1'b0;
      end else begin
         idle_evt <= 1'b0;
         if (done) armed <= 1'b1;
         if (!rx_en || busy || !rx) begin
            cnt <= '0;
         end else if (tick && armed) begin
            if (cnt == lim) begin
               cnt      <= '0;
               armed    <= 1'b0;
               idle_evt <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt |=> !idle_evt); // R8
endmodule

// File: rtl/uwr_flags.sv
module uwr_flags
   import uwr_pkg::*;
#(
   parameter int unsigned LONG  = 9,
   parameter int unsigned SHORT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              nine_bit,
   input  logic              wake_sel,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              stat_rd,
   input  logic              data_rd,
   input  logic              done,
   input  logic [LONG-1:0]   char_data,
   input  logic              idle_evt,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              full,
   output logic              idle,
   output logic [LONG-1:0]   rx_data,
   output logic              irq
);
   logic arm_f, arm_i;
   logic msb, wake_hit;

   assign msb      = nine_bit ? char_data[LONG-1] : char_data[SHORT-1];
   assign wake_hit = ctrl_q[CB_STBY] && (wake_sel ? (done && msb) : idle_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q[CB_STBY] <= ctrl_wdata[CB_STBY];
         ctrl_q[CB_FIE]  <= ctrl_wdata[CB_FIE];
         ctrl_q[CB_IIE]  <= ctrl_wdata[CB_IIE];
         if (mod_en) ctrl_q[CB_RXEN] <= ctrl_wdata[CB_RXEN];
      end else if (wake_hit) begin
         ctrl_q[CB_STBY] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         idle    <= 1'b0;
         arm_f   <= 1'b0;
         arm_i   <= 1'b0;
         rx_data <= '0;
      end else begin
         if (done) begin
            full    <= 1'b1;
            rx_data <= char_data;
         end else if (data_rd && arm_f) begin
            full <= 1'b0;
         end
         if (idle_evt)                idle <= 1'b1;
         else if (data_rd && arm_i)   idle <= 1'b0;
         if (data_rd) begin
            arm_f <= 1'b0;
            arm_i <= 1'b0;
         end else if (stat_rd) begin
            arm_f <= full;
            arm_i <= idle;
         end
      end
   end

   assign irq = !ctrl_q[CB_STBY] &&
                ((full && ctrl_q[CB_FIE]) || (idle && ctrl_q[CB_IIE]));

   AST_RXEN_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !mod_en) |=> (ctrl_q[CB_RXEN] == $past(ctrl_q[CB_RXEN]))); // R6
   AST_STBY_SET_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[CB_STBY]) |-> $past(ctrl_we)); // R5
   AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_STBY] && wake_sel && done && msb && !ctrl_we) |=> !ctrl_q[CB_STBY]); // R5
   AST_FULL_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full) |-> $past(data_rd)); // R9
   AST_IDLE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle) |-> $past(data_rd)); // R9
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
   import uwr_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned LONG        = 9,
   parameter int unsigned SHORT       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rxd,
   input  logic              mod_en,
   input  logic              nine_bit,
   input  logic              wake_sel,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              stat_rd,
   input  logic              data_rd,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              rx_full,
   output logic              rx_idle,
   output logic [LONG-1:0]   rx_data,
   output logic              irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (LONG <= SHORT || SHORT < 5) begin : g_bad_width
         $error("LONG must exceed SHORT, SHORT at least 5");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic            rx_s, busy, done, idle_evt;
   logic [LONG-1:0] char_data;

   uwr_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));

   uwr_framer #(.OVS(OVS), .LONG(LONG), .SHORT(SHORT)) i_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .rx_en(ctrl_q[CB_RXEN]), .nine_bit(nine_bit),
      .busy(busy), .done(done), .data(char_data));

   uwr_idle_det #(.OVS(OVS), .LONG(LONG), .SHORT(SHORT)) i_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .rx_en(ctrl_q[CB_RXEN]), .busy(busy), .done(done),
      .nine_bit(nine_bit), .idle_evt(idle_evt));

   uwr_flags #(.LONG(LONG), .SHORT(SHORT)) i_flags (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .nine_bit(nine_bit),
      .wake_sel(wake_sel), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .stat_rd(stat_rd), .data_rd(data_rd), .done(done),
      .char_data(char_data), .idle_evt(idle_evt), .ctrl_q(ctrl_q),
      .full(rx_full), .idle(rx_idle), .rx_data(rx_data), .irq(irq));

   AST_STBY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_STBY] |-> !irq); // R4
   AST_OFF_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_RXEN] |=> !$rose(rx_full)); // R3
   AST_OFF_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_RXEN] |=> $stable(rx_data)); // R3
   AST_NO_DONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_RXEN] |-> !done); // R3
endmodule

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic       mod_en = 1'b0, nine_bit = 1'b0, wake_sel = 1'b0;
   logic       ctrl_we = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
   logic [3:0] ctrl_wdata = '0;
   logic [3:0] ctrl_q;
   logic       rx_full, rx_idle, irq;
   logic [8:0] rx_data;

   int n_chk = 0, n_fail = 0;
   logic [3:0] m_ctrl = '0;
   localparam int BITCLK = 32;

   uart_wake_rx i_uart_wake_rx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .mod_en(mod_en),
      .nine_bit(nine_bit), .wake_sel(wake_sel), .ctrl_we(ctrl_we),
      .ctrl_wdata(ctrl_wdata), .stat_rd(stat_rd), .data_rd(data_rd),
      .ctrl_q(ctrl_q), .rx_full(rx_full), .rx_idle(rx_idle),
      .rx_data(rx_data), .irq(irq));

   always #5 clk = ~clk;
   always @(negedge clk) tick16 <= ~tick16;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference model of the enable bits, compared on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R6 enables", {ctrl_q[3:2], ctrl_q[0]}, {m_ctrl[3:2], m_ctrl[0]});
         if (ctrl_q[1]) chk("R4 standby mask", irq, 1'b0);
      end
   end

   task automatic wr(input logic [3:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(posedge clk);
      m_ctrl = mod_en ? v : {v[3:1], m_ctrl[0]};
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic pulse_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic pulse_data();
      @(negedge clk); data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0;
   endtask

   task automatic hold(input logic v, input int clocks);
      rxd = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input int nb);
      @(negedge clk);
      hold(1'b0, BITCLK);
      for (int i = 0; i < nb; i++) hold(d[i], BITCLK);
      hold(1'b1, BITCLK);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R7 ctrl reset", ctrl_q, 4'h0);
      chk("R7 full reset", rx_full, 1'b0);
      chk("R7 idle reset", rx_idle, 1'b0);
      chk("R7 irq reset", irq, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 ctrl after reset", ctrl_q, 4'h0);

      // R6: receiver enable locked while module disabled
      wr(4'b0001);
      chk("R6 rxen locked", ctrl_q[0], 1'b0);
      mod_en = 1'b1;
      wr(4'b0101);
      chk("R6 rxen written", ctrl_q[0], 1'b1);

      // R1/R2: 8-bit character with full interrupt enabled
      send(9'h0A5, 8);
      chk("R1 full set", rx_full, 1'b1);
      chk("R1 data 8-bit", rx_data, 9'h0A5);
      chk("R2 irq on full", irq, 1'b1);

      // R9: data read alone keeps flag, status then data clears
      pulse_data();
      chk("R9 data read alone", rx_full, 1'b1);
      pulse_stat();
      pulse_data();
      chk("R9 clear after sequence", rx_full, 1'b0);
      chk("R2 irq cleared", irq, 1'b0);

      // R2/R8: enable off, short gap gives no idle
      wr(4'b0001);
      send(9'h03C, 8);
      chk("R1 data 3C", rx_data, 9'h03C);
      chk("R2 irq masked by enable", irq, 1'b0);
      hold(1'b1, 5 * BITCLK);
      chk("R8 short gap no idle", rx_idle, 1'b0);
      pulse_stat(); pulse_data();

      // R8/R2: idle after full character time
      wr(4'b1001);
      send(9'h081, 8);
      hold(1'b1, 13 * BITCLK);
      chk("R8 idle set", rx_idle, 1'b1);
      chk("R2 irq on idle", irq, 1'b1);
      pulse_stat(); pulse_data();
      chk("R9 idle cleared", rx_idle, 1'b0);
      hold(1'b1, 13 * BITCLK);
      chk("R8 idle once per char", rx_idle, 1'b0);

      // R4/R5: standby, idle-line wake
      wake_sel = 1'b0;
      wr(4'b0111);
      send(9'h011, 8);
      chk("R4 full in standby", rx_full, 1'b1);
      chk("R4 irq masked", irq, 1'b0);
      chk("R5 standby held", ctrl_q[1], 1'b1);
      hold(1'b1, 13 * BITCLK);
      chk("R5 idle wake clears standby", ctrl_q[1], 1'b0);
      chk("R5 irq after wake", irq, 1'b1);
      pulse_stat(); pulse_data();

      // R5: address-mark wake in 9-bit mode
      nine_bit = 1'b1; wake_sel = 1'b1;
      wr(4'b0111);
      send(9'h055, 9);
      chk("R5 no wake on plain char", ctrl_q[1], 1'b1);
      chk("R5 plain char flagged", rx_full, 1'b1);
      chk("R4 irq masked 9-bit", irq, 1'b0);
      pulse_stat(); pulse_data();
      send(9'h1A3, 9);
      chk("R5 address wake", ctrl_q[1], 1'b0);
      chk("R5 address char data", rx_data, 9'h1A3);
      chk("R5 irq after address wake", irq, 1'b1);

      // R3: receiver off keeps flags and data
      wr(4'b0000);
      send(9'h077, 9);
      chk("R3 full kept", rx_full, 1'b1);
      chk("R3 data kept", rx_data, 9'h1A3);
      chk("R3 idle unchanged", rx_idle, 1'b0);

      // R10: short start glitch rejected
      pulse_stat(); pulse_data();
      nine_bit = 1'b0;
      wr(4'b0001);
      hold(1'b0, 12);
      hold(1'b1, 4 * BITCLK);
      chk("R10 glitch rejected", rx_full, 1'b0);
      send(9'h05A, 8);
      chk("R10 char after glitch", rx_data, 9'h05A);
      chk("R1 full after glitch", rx_full, 1'b1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule